// File: doc/BRIEF.md
# Boot patch image validator

This block checks a boot-time configuration patch image held in a byte-wide shadow RAM, then unpacks it. On a start pulse it reads the image one byte per request, from address 0 upward. Only one read is outstanding at a time, and the read data arrives on the cycle after the request. The image is three sections back to back: a 28-byte global header, an init-code section and a power-down-code section. Each section carries its own checksum byte. All multi-byte fields are stored most significant byte first.

While it reads, the block runs a zero-sum check over each section. It also checks the coded hunk counts and the size fields, and it stops at the first fault, which it reports with a numeric error code. When it finishes, the decoded header fields are on dedicated outputs. A five-entry hunk table is also available, giving each code hunk's trigger tag, its size in bytes and its absolute byte offset in the image. A later stage can then fetch and execute the hunks without parsing the image again.

Top module: `patch_image_checker`

## Requirements
- R1: After an accepted start, the block raises mem_rd for one cycle per byte, with mem_addr running 0, 1, 2, ... in strict order. It takes mem_rdata on the cycle after each request. It makes no further request once it has stopped. The total number of reads is 28 + 12 + T + 8 + P for a valid image, where T is the init total-size byte (image offset 31) and P is the power-down total-size byte.
- R2: If byte 0 is not 0xA5, the block finishes with err_code 1 after exactly one read.
- R3: The header fields are decoded big-endian at these offsets:
  - format is byte 1 bits 7-3, and revision is byte 1 bits 2-0;
  - MAC is bytes 2-7;
  - subsystem device ID is bytes 8-9, subsystem vendor ID is bytes 10-11, and device ID is bytes 12-13;
  - basic config is bytes 22-23;
  - version is bytes 26-27, with variant in bits 15-11, major in bits 10-8 and minor in bits 7-0.
- R4: If the 8-bit sum of header bytes 0-27 is nonzero, the block finishes with err_code 2 after 28 reads.
- R5: In the init section, which starts at offset 28, the hunk-count code sits at offset 30. The accepted codes are 0x80, and 0x60 when the fourth (tag, size) pair at offsets 38-39 is zero. Any other case gives err_code 3 after 40 reads.
- R6: When the count is accepted, the four init sizes (offsets 33, 35, 37, 39) must each be a multiple of 4 and must sum to the total-size byte at offset 31. Otherwise the block gives err_code 4 after 40 reads. A count fault takes precedence over a size fault.
- R7: If the 8-bit sum of init bytes 28 through 39+T is nonzero, the block gives err_code 5 after 40+T reads.
- R8: The power-down section starts at offset Q = 40+T. Its layout is checksum, unused byte, count code, total size, one (tag, size) pair, then two padding bytes. Three checks apply, in this order:
  - a count other than 0x20, or nonzero padding, gives err_code 6;
  - a size unequal to the total, or a size that is not a multiple of 4, gives err_code 7;
  - both of these stop the block after Q+8 reads;
  - a nonzero sum over Q through Q+7+P gives err_code 8.
- R9: The hunk table has five entries, each 8 bits of tag and 8 bits of size. Entries 0-3 are the init hunks and entry 4 is the power-down hunk. Each offset field is ADDR_W bits wide. The offsets run 40, then 40 plus each preceding init size, and 48+T for entry 4. hunk_valid is 5'b11111 when the count code is 0x80 and 5'b10111 when it is 0x60, and it is zero unless pass is set.
- R10: busy is high during a run. done rises at the end of the run and holds until the next accepted start. pass is high exactly when err_code is 0. A start pulse seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a validation run (ignored while busy) |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | Image accepted |
| err_code | output | 4 | 0 ok, 1-8 fault codes per R2-R8 |
| fmt_o | output | 5 | Patch format |
| rev_o | output | 3 | Patch revision |
| mac_o | output | 48 | MAC address, first byte in bits 47-40 |
| sub_dev_o | output | 16 | Subsystem device ID |
| sub_ven_o | output | 16 | Subsystem vendor ID |
| dev_id_o | output | 16 | Device ID |
| basic_cfg_o | output | 16 | Basic configuration word |
| ver_var_o | output | 5 | Version variant |
| ver_maj_o | output | 3 | Version major |
| ver_min_o | output | 8 | Version minor |
| hunk_valid | output | 5 | Valid mask of hunk table entries |
| hunk_tag | output | 40 | Entry k tag at bits [8k+7:8k] |
| hunk_len | output | 40 | Entry k size at bits [8k+7:8k] |
| hunk_off | output | 5*ADDR_W | Entry k absolute offset at bits [ADDR_W*k +: ADDR_W] |

## Verification
The bench sweeps every combination of hunk sizes 0, 4 and 8 in both hunk-count modes, with two power-down sizes. This catches any design that computes a hunk offset from the wrong predecessor or miscounts section ends. It also catches a design that mishandles the zero-length code case, where a section's last byte is its table byte. Each fault is planted on its own and checked by error code and by exact read count, which exposes a checker that aborts late, keeps reading past a fault or tests faults in the wrong precedence. Further cases cover:
- a 3-hunk image whose padding pair is nonzero;
- sizes that sum correctly but are not multiples of 4;
- a start pulse in mid-run, which a wrong design would let restart the scan.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int HDR_LEN      = 28;
   localparam int INIT_TBL_LEN = 12;
   localparam int PD_TBL_LEN   = 8;
   localparam int INIT_HUNKS   = 4;
   localparam int ALL_HUNKS    = INIT_HUNKS + 1;
   localparam int INIT_CODE    = HDR_LEN + INIT_TBL_LEN;
   localparam int MAX_IMAGE    = INIT_CODE + 255 + PD_TBL_LEN + 255;

   localparam int H_FMT  = 1;
   localparam int H_MAC0 = 2;
   localparam int H_MAC5 = 7;
   localparam int H_SDEV = 8;
   localparam int H_SVEN = 10;
   localparam int H_DEV  = 12;
   localparam int H_CFG  = 22;
   localparam int H_VER  = 26;
   localparam int H_LAST = HDR_LEN - 1;

   localparam int S_CNT   = 2;
   localparam int S_TOT   = 3;
   localparam int S_PAIR0 = 4;
   localparam int P_PAD   = 6;

   localparam logic [7:0] CNT_THREE = 8'h60;
   localparam logic [7:0] CNT_FOUR  = 8'h80;
   localparam logic [7:0] CNT_ONE   = 8'h20;

   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_USE, ST_DONE} st_e;
   typedef enum logic [1:0] {SEC_HDR, SEC_INIT, SEC_PD} sec_e;
   typedef enum logic [3:0] {
      ERR_NONE      = 4'd0,
      ERR_SIG       = 4'd1,
      ERR_HDR_SUM   = 4'd2,
      ERR_INIT_CNT  = 4'd3,
      ERR_INIT_SIZE = 4'd4,
      ERR_INIT_SUM  = 4'd5,
      ERR_PD_CNT    = 4'd6,
      ERR_PD_SIZE   = 4'd7,
      ERR_PD_SUM    = 4'd8
   } err_e;
endpackage

// File: rtl/pic_sum_acc.sv
module pic_sum_acc #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          first,
   input  logic [DW-1:0] data,
   output logic [DW-1:0] nsum
);
   logic [DW-1:0] acc;

   assign nsum = (first ? '0 : acc) + data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= nsum;
   end
endmodule

// File: rtl/pic_hdr_fields.sv
module pic_hdr_fields
   import pic_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic [4:0]  rel,
   input  logic [7:0]  d,
   output logic [4:0]  fmt_o,
   output logic [2:0]  rev_o,
   output logic [47:0] mac_o,
   output logic [15:0] sub_dev_o,
   output logic [15:0] sub_ven_o,
   output logic [15:0] dev_id_o,
   output logic [15:0] basic_cfg_o,
   output logic [4:0]  ver_var_o,
   output logic [2:0]  ver_maj_o,
   output logic [7:0]  ver_min_o
);
   logic [7:0]  fmt_q;
   logic [15:0] ver_q;
   logic [4:0]  r;

   assign r = rel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         fmt_q       <= '0;
         mac_o       <= '0;
         sub_dev_o   <= '0;
         sub_ven_o   <= '0;
         dev_id_o    <= '0;
         basic_cfg_o <= '0;
         ver_q       <= '0;
      end else if (en) begin
         if (r == 5'(H_FMT))                       fmt_q       <= d;
         if (r >= 5'(H_MAC0) && r <= 5'(H_MAC5))   mac_o       <= {mac_o[39:0], d};
         if (r == 5'(H_SDEV) || r == 5'(H_SDEV+1)) sub_dev_o   <= {sub_dev_o[7:0], d};
         if (r == 5'(H_SVEN) || r == 5'(H_SVEN+1)) sub_ven_o   <= {sub_ven_o[7:0], d};
         if (r == 5'(H_DEV)  || r == 5'(H_DEV+1))  dev_id_o    <= {dev_id_o[7:0], d};
         if (r == 5'(H_CFG)  || r == 5'(H_CFG+1))  basic_cfg_o <= {basic_cfg_o[7:0], d};
         if (r == 5'(H_VER)  || r == 5'(H_VER+1))  ver_q       <= {ver_q[7:0], d};
      end
   end

   assign fmt_o     = fmt_q[7:3];
   assign rev_o     = fmt_q[2:0];
   assign ver_var_o = ver_q[15:11];
   assign ver_maj_o = ver_q[10:8];
   assign ver_min_o = ver_q[7:0];
endmodule

// File: rtl/pic_hunk_map.sv
module pic_hunk_map
   import pic_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int NH     = ALL_HUNKS
) (
   input  logic [(NH-1)*8-1:0] sizes,
   output logic [NH*ADDR_W-1:0] offs
);
   logic [ADDR_W-1:0] off [NH];

   for (genvar k = 0; k < NH; k++) begin : g_off
      if (k == 0) begin : g_first
         assign off[k] = ADDR_W'(INIT_CODE);
      end else if (k == NH-1) begin : g_pd
         assign off[k] = off[k-1] + ADDR_W'(sizes[(k-1)*8 +: 8]) + ADDR_W'(PD_TBL_LEN);
      end else begin : g_mid
         assign off[k] = off[k-1] + ADDR_W'(sizes[(k-1)*8 +: 8]);
      end
      assign offs[k*ADDR_W +: ADDR_W] = off[k];
   end
endmodule

// File: rtl/patch_image_checker.sv
module patch_image_checker
   import pic_pkg::*;
#(
   parameter int         ADDR_W   = 10,
   parameter logic [7:0] SIG_BYTE = 8'hA5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   output logic                      mem_rd,
   output logic [ADDR_W-1:0]         mem_addr,
   input  logic [7:0]                mem_rdata,
   output logic                      busy,
   output logic                      done,
   output logic                      pass,
   output logic [3:0]                err_code,
   output logic [4:0]                fmt_o,
   output logic [2:0]                rev_o,
   output logic [47:0]               mac_o,
   output logic [15:0]               sub_dev_o,
   output logic [15:0]               sub_ven_o,
   output logic [15:0]               dev_id_o,
   output logic [15:0]               basic_cfg_o,
   output logic [4:0]                ver_var_o,
   output logic [2:0]                ver_maj_o,
   output logic [7:0]                ver_min_o,
   output logic [ALL_HUNKS-1:0]      hunk_valid,
   output logic [ALL_HUNKS*8-1:0]    hunk_tag,
   output logic [ALL_HUNKS*8-1:0]    hunk_len,
   output logic [ALL_HUNKS*ADDR_W-1:0] hunk_off
);
   localparam int REL_W = 9;

   if ((1 << ADDR_W) < MAX_IMAGE) begin : g_bad_addr_w
      $error("ADDR_W cannot span the largest image");
   end

   st_e              state;
   sec_e             sec;
   logic [REL_W-1:0] rel;
   logic [ADDR_W-1:0] addr;
   err_e             err_q, fault;
   logic             pass_q, go, use_byte, sec_end, finish;
   logic [7:0]       d, nsum;
   logic [7:0]       icnt, itot, pcnt, ptot, ptag, psz, ppad;
   logic [7:0]       itag [INIT_HUNKS];
   logic [7:0]       isz  [INIT_HUNKS];
   logic [9:0]       isz_total;
   logic             cnt_ok, size_ok, pcnt_ok, psize_ok;

   assign d        = mem_rdata;
   assign go       = start && (state == ST_IDLE || state == ST_DONE);
   assign use_byte = (state == ST_USE);
   assign mem_rd   = (state == ST_REQ);
   assign mem_addr = addr;
   assign busy     = (state == ST_REQ) || (state == ST_USE);
   assign done     = (state == ST_DONE);
   assign pass     = pass_q;
   assign err_code = err_q;

   pic_sum_acc #(.DW(8)) u_sum (
      .clk(clk), .rst_n(rst_n), .en(use_byte), .first(rel == '0),
      .data(d), .nsum(nsum)
   );

   pic_hdr_fields u_hdr (
      .clk(clk), .rst_n(rst_n), .clr(go), .en(use_byte && sec == SEC_HDR),
      .rel(rel[4:0]), .d(d),
      .fmt_o(fmt_o), .rev_o(rev_o), .mac_o(mac_o), .sub_dev_o(sub_dev_o),
      .sub_ven_o(sub_ven_o), .dev_id_o(dev_id_o), .basic_cfg_o(basic_cfg_o),
      .ver_var_o(ver_var_o), .ver_maj_o(ver_maj_o), .ver_min_o(ver_min_o)
   );

   // table capture for the two code sections
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || go) begin
         icnt <= '0; itot <= '0; pcnt <= '0; ptot <= '0;
         ptag <= '0; psz <= '0; ppad <= '0;
      end else if (use_byte && sec == SEC_INIT) begin
         if (rel == REL_W'(S_CNT)) icnt <= d;
         if (rel == REL_W'(S_TOT)) itot <= d;
      end else if (use_byte && sec == SEC_PD) begin
         if (rel == REL_W'(S_CNT))   pcnt <= d;
         if (rel == REL_W'(S_TOT))   ptot <= d;
         if (rel == REL_W'(S_PAIR0)) ptag <= d;
         if (rel == REL_W'(S_PAIR0+1)) psz <= d;
         if (rel == REL_W'(P_PAD))   ppad <= d;
      end
   end

   for (genvar k = 0; k < INIT_HUNKS; k++) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n || go) begin
            itag[k] <= '0;
            isz[k]  <= '0;
         end else if (use_byte && sec == SEC_INIT) begin
            if (rel == REL_W'(S_PAIR0 + 2*k))     itag[k] <= d;
            if (rel == REL_W'(S_PAIR0 + 2*k + 1)) isz[k]  <= d;
         end
      end
      assign hunk_tag[k*8 +: 8] = itag[k];
      assign hunk_len[k*8 +: 8] = isz[k];
   end
   assign hunk_tag[INIT_HUNKS*8 +: 8] = ptag;
   assign hunk_len[INIT_HUNKS*8 +: 8] = psz;

   pic_hunk_map #(.ADDR_W(ADDR_W), .NH(ALL_HUNKS)) u_map (
      .sizes(hunk_len[INIT_HUNKS*8-1:0]), .offs(hunk_off)
   );

   assign hunk_valid = pass_q ? {1'b1, icnt == CNT_FOUR, 3'b111} : '0;

   // the last init size arrives on the table's final byte, so it is taken from d
   assign isz_total = 10'(isz[0]) + 10'(isz[1]) + 10'(isz[2]) + 10'(d);
   assign cnt_ok    = (icnt == CNT_FOUR) ||
                      (icnt == CNT_THREE && itag[3] == '0 && d == '0);
   assign size_ok   = (isz_total == 10'(itot)) && ((isz[0] | isz[1] | isz[2] | d) & 8'h03) == '0;
   assign pcnt_ok   = (pcnt == CNT_ONE) && (ppad == '0) && (d == '0);
   assign psize_ok  = (psz == ptot) && (psz[1:0] == 2'b00);

   always_comb begin
      fault   = ERR_NONE;
      sec_end = 1'b0;
      unique case (sec)
         SEC_HDR: begin
            if (rel == '0 && d != SIG_BYTE) fault = ERR_SIG;
            else if (rel == REL_W'(H_LAST)) begin
               sec_end = 1'b1;
               if (nsum != '0) fault = ERR_HDR_SUM;
            end
         end
         SEC_INIT: begin
            if (rel == REL_W'(INIT_TBL_LEN-1)) begin
               if (!cnt_ok)       fault = ERR_INIT_CNT;
               else if (!size_ok) fault = ERR_INIT_SIZE;
            end
            if (fault == ERR_NONE && rel == REL_W'(INIT_TBL_LEN-1) + REL_W'(itot)) begin
               sec_end = 1'b1;
               if (nsum != '0) fault = ERR_INIT_SUM;
            end
         end
         default: begin
            if (rel == REL_W'(PD_TBL_LEN-1)) begin
               if (!pcnt_ok)       fault = ERR_PD_CNT;
               else if (!psize_ok) fault = ERR_PD_SIZE;
            end
            if (fault == ERR_NONE && rel == REL_W'(PD_TBL_LEN-1) + REL_W'(ptot)) begin
               sec_end = 1'b1;
               if (nsum != '0) fault = ERR_PD_SUM;
            end
         end
      endcase
      finish = (fault != ERR_NONE) || (sec_end && sec == SEC_PD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; sec <= SEC_HDR; rel <= '0; addr <= '0;
         err_q <= ERR_NONE; pass_q <= 1'b0;
      end else begin
         unique case (state)
            ST_REQ: state <= ST_USE;
            ST_USE: begin
               if (finish) begin
                  state  <= ST_DONE;
                  err_q  <= fault;
                  pass_q <= (fault == ERR_NONE);
               end else begin
                  state <= ST_REQ;
                  addr  <= addr + ADDR_W'(1);
                  if (sec_end) begin
                     sec <= (sec == SEC_HDR) ? SEC_INIT : SEC_PD;
                     rel <= '0;
                  end else begin
                     rel <= rel + REL_W'(1);
                  end
               end
            end
            default: if (start) begin
               state <= ST_REQ; sec <= SEC_HDR; rel <= '0; addr <= '0;
               err_q <= ERR_NONE; pass_q <= 1'b0;
            end
         endcase
      end
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQ && $past(state) == ST_USE) |-> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R1
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd); // R1
   AST_SIG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (use_byte && sec == SEC_HDR && rel == '0 && mem_rdata != SIG_BYTE) |=> (done && err_code == 4'd1)); // R2
   AST_HDR_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sec == SEC_INIT && $past(sec) == SEC_HDR) |-> $past(nsum) == 8'd0); // R4
   AST_PASS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> (icnt == CNT_THREE || icnt == CNT_FOUR) && pcnt == CNT_ONE); // R5
   AST_PASS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> (done && err_code == 4'd0)); // R10
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(err_code))); // R10
endmodule

// File: tb/patch_image_checker_tb.sv
module patch_image_checker_tb;
   localparam int ADDR_W = 10;
   localparam int MEM_N  = 1 << ADDR_W;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic mem_rd;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0] mem_rdata = 8'h00;
   logic busy, done, pass;
   logic [3:0] err_code;
   logic [4:0] fmt_o, ver_var_o;
   logic [2:0] rev_o, ver_maj_o;
   logic [47:0] mac_o;
   logic [15:0] sub_dev_o, sub_ven_o, dev_id_o, basic_cfg_o;
   logic [7:0] ver_min_o;
   logic [4:0] hunk_valid;
   logic [39:0] hunk_tag, hunk_len;
   logic [5*ADDR_W-1:0] hunk_off;

   always #2 clk = ~clk;

   patch_image_checker #(.ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .pass(pass), .err_code(err_code),
      .fmt_o(fmt_o), .rev_o(rev_o), .mac_o(mac_o), .sub_dev_o(sub_dev_o),
      .sub_ven_o(sub_ven_o), .dev_id_o(dev_id_o), .basic_cfg_o(basic_cfg_o),
      .ver_var_o(ver_var_o), .ver_maj_o(ver_maj_o), .ver_min_o(ver_min_o),
      .hunk_valid(hunk_valid), .hunk_tag(hunk_tag), .hunk_len(hunk_len), .hunk_off(hunk_off)
   );

   logic [7:0] img [0:MEM_N-1];
   int nreads = 0, run_base = 0, seq_err = 0, cycles = 0;
   int tests = 0, fails = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_rd) begin
         mem_rdata <= img[mem_addr];
         nreads    <= nreads + 1;
         if (mem_addr != ADDR_W'(nreads - run_base)) seq_err <= seq_err + 1;
      end
   end

   initial begin
      @(posedge clk);
      while (cycles < 190000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: run did not end act=%0d exp=<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // image configuration
   int c_cnt, c_tot, p_cnt, p_tot, p_sz, p_pad, seed;
   int c_sz [4];
   int c_tag [4];

   task automatic defaults();
      c_cnt = 'h80; c_sz = '{8, 4, 12, 4}; c_tag = '{'h10, 'h30, 'hA8, 'hD8};
      c_tot = 28; p_cnt = 'h20; p_sz = 8; p_tot = 8; p_pad = 0;
   endtask

   function automatic int pd_base();
      return 40 + c_tot;
   endfunction

   task automatic seal_range(input int lo, input int hi);
      logic [7:0] s = 8'h00;
      for (int i = lo + 1; i <= hi; i++) s = s + img[i];
      img[lo] = 8'h00 - s;
   endtask

   task automatic seal();
      logic [7:0] s = 8'h00;
      for (int i = 0; i < 28; i++) if (i != 24) s = s + img[i];
      img[24] = 8'h00 - s;
      seal_range(28, 39 + c_tot);
      seal_range(pd_base(), pd_base() + 7 + p_tot);
   endtask

   task automatic build();
      int q;
      for (int i = 0; i < MEM_N; i++) img[i] = 8'h00;
      for (int i = 1; i < 28; i++) img[i] = 8'(i * 29 + seed * 7 + 3);
      img[0] = 8'hA5;
      img[29] = 8'h5A; img[30] = 8'(c_cnt); img[31] = 8'(c_tot);
      for (int k = 0; k < 4; k++) begin
         img[32 + 2*k] = 8'(c_tag[k]);
         img[33 + 2*k] = 8'(c_sz[k]);
      end
      for (int i = 0; i < c_tot; i++) img[40 + i] = 8'(i * 13 + seed + 1);
      q = pd_base();
      img[q+1] = 8'hC3; img[q+2] = 8'(p_cnt); img[q+3] = 8'(p_tot);
      img[q+4] = 8'h50; img[q+5] = 8'(p_sz); img[q+6] = 8'(p_pad); img[q+7] = 8'h00;
      for (int i = 0; i < p_tot; i++) img[q + 8 + i] = 8'(i * 7 + seed + 5);
      seal();
   endtask

   // run one validation; poke >= 0 pulses start that many cycles into the run
   task automatic run(input int exp_err, input int exp_reads, input string req, input int poke);
      int n = 0;
      run_base = nreads;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done && n < 3000) begin
         start = (n == poke);
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(done, req, "done after run", done, 1);
      chk(err_code == 4'(exp_err), req, "err_code", err_code, exp_err);
      chk(pass == (exp_err == 0), "R10", "pass vs error", pass, exp_err == 0);
      chk(nreads - run_base == exp_reads && seq_err == 0, "R1", "read count / order",
          nreads - run_base, exp_reads);
   endtask

   task automatic check_table();
      bit ok = 1'b1;
      int off = 40;
      logic [4:0] v = {1'b1, c_cnt == 'h80, 3'b111};
      for (int k = 0; k < 4; k++) begin
         if (hunk_tag[k*8 +: 8] != 8'(c_tag[k]) || hunk_len[k*8 +: 8] != 8'(c_sz[k]) ||
             hunk_off[k*ADDR_W +: ADDR_W] != ADDR_W'(off)) ok = 1'b0;
         off += c_sz[k];
      end
      if (hunk_tag[32 +: 8] != 8'h50 || hunk_len[32 +: 8] != 8'(p_sz) ||
          hunk_off[4*ADDR_W +: ADDR_W] != ADDR_W'(48 + c_tot)) ok = 1'b0;
      chk(ok, "R9", "hunk table pd offset", hunk_off[4*ADDR_W +: ADDR_W], 48 + c_tot);
      chk(hunk_valid == v, "R9", "hunk_valid", hunk_valid, v);
   endtask

   task automatic check_header();
      bit ok;
      ok = fmt_o == img[1][7:3] && rev_o == img[1][2:0] &&
           mac_o == {img[2], img[3], img[4], img[5], img[6], img[7]} &&
           sub_dev_o == {img[8], img[9]} && sub_ven_o == {img[10], img[11]} &&
           dev_id_o == {img[12], img[13]} && basic_cfg_o == {img[22], img[23]} &&
           ver_var_o == img[26][7:3] && ver_maj_o == img[26][2:0] && ver_min_o == img[27];
      chk(ok, "R3", "header mac", mac_o, {img[2], img[3], img[4], img[5], img[6], img[7]});
   endtask

   initial begin
      seed = 0;
      defaults();
      build();
      repeat (3) @(negedge clk);
      chk(!busy && !done && !pass && err_code == 0 && !mem_rd, "R10", "reset state",
          {busy, done, pass, mem_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep of hunk sizes in both count modes
      for (int mode = 0; mode < 2; mode++)
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               for (int c = 0; c < 3; c++)
                  for (int e = 0; e < (mode ? 3 : 1); e++)
                     for (int p = 0; p < 2; p++) begin
                        seed++;
                        defaults();
                        c_cnt = mode ? 'h80 : 'h60;
                        c_sz = '{4*a, 4*b, 4*c, 4*e};
                        if (!mode) c_tag[3] = 0;
                        c_tot = 4*(a + b + c + e);
                        p_sz = 12*p; p_tot = 12*p;
                        build();
                        run(0, 48 + c_tot + p_tot, "R9", -1);
                        check_table();
                        check_header();
                     end

      defaults(); build(); img[0] = 8'hA4; seal();
      run(1, 1, "R2", -1);
      defaults(); build(); img[24] = img[24] ^ 8'h01;
      run(2, 28, "R4", -1);
      defaults(); c_cnt = 'h40; build();
      run(3, 40, "R5", -1);
      defaults(); c_cnt = 'h60; c_sz = '{8, 4, 12, 4}; build();
      run(3, 40, "R5", -1);
      defaults(); c_cnt = 'h60; c_sz = '{8, 4, 12, 0}; c_tot = 24; c_tag[3] = 'h08; build();
      run(3, 40, "R5", -1);
      defaults(); c_tot = 32; build();
      run(4, 40, "R6", -1);
      defaults(); c_sz = '{2, 6, 4, 4}; c_tot = 16; build();
      run(4, 40, "R6", -1);
      defaults(); c_cnt = 'h41; c_tot = 32; build();
      run(3, 40, "R6", -1);
      defaults(); build(); img[45] = img[45] + 8'h01;
      run(5, 40 + c_tot, "R7", -1);
      defaults(); c_sz = '{0, 0, 0, 0}; c_tot = 0; build(); img[35] = 8'h00; img[28] = img[28] + 8'h01;
      run(5, 40, "R7", -1);
      defaults(); p_cnt = 'h40; build();
      run(6, 48 + c_tot, "R8", -1);
      defaults(); p_pad = 1; build();
      run(6, 48 + c_tot, "R8", -1);
      defaults(); p_tot = 12; build();
      run(7, 48 + c_tot, "R8", -1);
      defaults(); p_sz = 2; p_tot = 2; build();
      run(7, 48 + c_tot, "R8", -1);
      defaults(); build(); img[pd_base() + 9] = img[pd_base() + 9] ^ 8'h80;
      run(8, 48 + c_tot + p_tot, "R8", -1);
      defaults(); p_sz = 0; p_tot = 0; build(); img[pd_base()] = img[pd_base()] + 8'h01;
      run(8, 48 + c_tot, "R8", -1);

      defaults(); build();
      run(0, 48 + c_tot + p_tot, "R10", 20);
      check_table();
      repeat (4) @(negedge clk);
      chk(done && pass && err_code == 0 && !mem_rd, "R10", "done holds without start",
          {done, pass, mem_rd}, 3'b110);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule